// File: doc/BRIEF.md
# Status Register and Write-Protection Guard

This block keeps the status byte of a serial memory and rules on every write that the host requests. A serial front end, outside this block, decodes the host's commands. It presents each decoded command as a one-cycle strobe with an operation code, an array address and a data byte. The block keeps a write-enable latch and stores the watchdog-period and block-protect fields. It also enforces two protections: the hardware write-protect pin, which acts only while the protect-enable bit is set, and region protection of the array. The full status byte is always readable, including while a write is in progress, so the host can poll the ready bit.

Array writes are ruled on at once. A status write is checked when it is requested and then held pending until chip select rises, which is when the internal write starts. If the protect pin drops while the write is still pending and chip select is still low, the write is cancelled. Once chip select has risen, the pin no longer affects that write. A write sequencer outside the block reports its progress on the `busy` input. While `busy` is high, every command is ignored.

Top module: `status_guard`

## Requirements
- R1: After reset the status byte reads 0x00 while `busy` is low. Bit 6 always reads 0.
- R2: Status bit 0 (ready/busy) follows the `busy` input in the same cycle and reads 1 during a write. The byte is readable at any time.
- R3: Operation code 1 sets the write-enable latch (status bit 1) and code 2 clears it. Codes 0, 5, 6 and 7 have no effect.
- R4: While `busy` is high, or while a status write is pending, commands are ignored: no grant or deny pulse appears and the status byte does not change.
- R5: An array write (code 4) gives a one-cycle `arr_grant` in the cycle after the strobe if the write-enable latch is set and the address is not protected. Otherwise it gives a one-cycle `arr_deny`.
- R6: Block protect is bits 3:2. The value 00 protects nothing, 01 protects the top quarter of the address space (the two top address bits are 11), 10 protects the top half (the top address bit is 1), and 11 protects every address.
- R7: The write-enable latch reads 0 after every array or status write command, whether it is granted, denied or cancelled.
- R8: A status write (code 3) stores data bits 7, 5, 4, 3 and 2 in the same status positions. The store happens in the first cycle after acceptance in which `cs_n` is high, and it is marked by a one-cycle `sts_grant`. Status bits 1 and 0 cannot be written.
- R9: A status write requested without the write-enable latch set, or while bit 7 is 1 and `wp_n` is low, gives `sts_deny` in the next cycle and leaves the stored fields unchanged.
- R10: While bit 7 is 0, `wp_n` has no effect on status writes.
- R11: While a status write is pending with bit 7 set, `wp_n` low in a cycle where `cs_n` is low cancels the write with `sts_deny`. If `cs_n` is high in that cycle, the write is stored regardless of `wp_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Operation code (1 set latch, 2 clear latch, 3 status write, 4 array write) |
| cmd_addr | input | ADDR_W | Array address of a write |
| cmd_data | input | 8 | New status byte for a status write |
| cs_n | input | 1 | Chip select level; high means the internal write starts |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| busy | input | 1 | Internal write in progress, from the sequencer |
| status_rd | output | 8 | Current status byte |
| arr_grant | output | 1 | Array write allowed |
| arr_deny | output | 1 | Array write refused |
| sts_grant | output | 1 | Status write stored |
| sts_deny | output | 1 | Status write refused or cancelled |

## Verification
The bench builds the block with a 6-bit address, so the quarter, half and full region edges sit at 0x30, 0x20 and 0x00. This lets a few writes land exactly on each side of every edge. Directed steps cover the abort window, where the protect pin drops before or at the rise of chip select, and the case where the protect pin is inert because bit 7 is 0. A random phase then drives the pin, chip select and `busy` freely against the reference model, so that pending writes meet every combination of these inputs.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_WEL_SET = 3'd1,
    OP_WEL_CLR = 3'd2,
    OP_STS_WR  = 3'd3,
    OP_ARR_WR  = 3'd4
  } sg_op_e;

  localparam int SB_PEN  = 7;
  localparam int SB_WDH  = 5;
  localparam int SB_WDL  = 4;
  localparam int SB_BPH  = 3;
  localparam int SB_BPL  = 2;
  localparam int SB_WEL  = 1;
  localparam int SB_RDY  = 0;
endpackage

// File: rtl/sg_rst_sync.sv
module sg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/sg_region_chk.sv
module sg_region_chk #(
  parameter int ADDR_W = 10
) (
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              prot
);
  localparam int TOP = ADDR_W - 1;

  logic in_half, in_quarter;

  assign in_half = addr[TOP];

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign in_quarter = (addr[TOP -: 2] == 2'b11);
    end else begin : g_narrow
      assign in_quarter = addr[TOP];
    end
  endgenerate

  always_comb begin
    case (bp)
      2'b00:   prot = 1'b0;
      2'b01:   prot = in_quarter;
      2'b10:   prot = in_half;
      default: prot = 1'b1;
    endcase
  end
endmodule

// File: rtl/sg_wel.sv
module sg_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_q
);
  logic wel_d;

  always_comb begin
    wel_d = wel_q;
    if (clr_i)      wel_d = 1'b0;
    else if (set_i) wel_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wel_q <= 1'b0;
    else        wel_q <= wel_d;
  end
endmodule

// File: rtl/sg_sts_ctl.sv
module sg_sts_ctl
  import sg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       accept_i,
  input  logic [7:0] data_i,
  input  logic       cs_n,
  input  logic       wp_n,
  output logic       pend_q,
  output logic       pen_q,
  output logic [1:0] wd_q,
  output logic [1:0] bp_q,
  output logic       grant_q,
  output logic       deny_q,
  output logic       done_o
);
  logic       commit, cancel, take;
  logic       pend_d, grant_d, deny_d;
  logic [4:0] buf_q, buf_d;
  logic       sts_unused_bits;

  assign sts_unused_bits = ^{data_i[6], data_i[1:0]};

  assign take   = req_i && accept_i;
  assign commit = pend_q && cs_n;
  assign cancel = pend_q && !cs_n && pen_q && !wp_n;
  assign done_o = commit || cancel;

  always_comb begin
    pend_d  = pend_q;
    buf_d   = buf_q;
    if (commit || cancel) pend_d = 1'b0;
    else if (take)        pend_d = 1'b1;
    if (take) buf_d = {data_i[SB_PEN], data_i[SB_WDH], data_i[SB_WDL],
                       data_i[SB_BPH], data_i[SB_BPL]};
    grant_d = commit;
    deny_d  = cancel || (req_i && !accept_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      buf_q   <= '0;
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      grant_q <= grant_d;
      deny_q  <= deny_d;
      if (take) buf_q <= buf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen_q <= 1'b0;
      wd_q  <= 2'b00;
      bp_q  <= 2'b00;
    end else if (commit) begin
      pen_q <= buf_q[4];
      wd_q  <= buf_q[3:2];
      bp_q  <= buf_q[1:0];
    end
  end

  a_r8_fields_move_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({pen_q, wd_q, bp_q}) |-> ($past(pend_q) && $past(cs_n)));

  a_r11_abort_on_wp_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !cs_n && pen_q && !wp_n) |=> (deny_q && !pend_q));

  a_r11_started_write_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && cs_n) |=> (grant_q && !deny_q));
endmodule

// File: rtl/status_guard.sv
module status_guard
  import sg_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              cs_n,
  input  logic              wp_n,
  input  logic              busy,
  output logic [7:0]        status_rd,
  output logic              arr_grant,
  output logic              arr_deny,
  output logic              sts_grant,
  output logic              sts_deny
);
  logic       rst_i;
  logic       pend, pen, wel, prot, sts_done;
  logic [1:0] wd, bp;
  logic       cmd_ok, hw_lock, sts_req, sts_accept, arr_req, arr_ok;
  logic       wel_set, wel_clr;
  logic       arr_grant_d, arr_deny_d, arr_grant_q, arr_deny_q;
  sg_op_e     op;

  sg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i));

  sg_region_chk #(.ADDR_W(ADDR_W)) u_region (.bp(bp), .addr(cmd_addr), .prot(prot));

  assign op         = sg_op_e'(cmd_op);
  assign cmd_ok     = cmd_valid && !busy && !pend;
  assign hw_lock    = pen && !wp_n;
  assign sts_req    = cmd_ok && (op == OP_STS_WR);
  assign sts_accept = wel && !hw_lock;
  assign arr_req    = cmd_ok && (op == OP_ARR_WR);
  assign arr_ok     = wel && !prot;

  assign wel_set = cmd_ok && (op == OP_WEL_SET);
  assign wel_clr = (cmd_ok && ((op == OP_WEL_CLR) || (op == OP_ARR_WR) ||
                               ((op == OP_STS_WR) && !sts_accept))) || sts_done;

  sg_wel u_wel (.clk(clk), .rst_n(rst_i), .set_i(wel_set), .clr_i(wel_clr), .wel_q(wel));

  sg_sts_ctl u_sts (
    .clk(clk), .rst_n(rst_i), .req_i(sts_req), .accept_i(sts_accept),
    .data_i(cmd_data), .cs_n(cs_n), .wp_n(wp_n), .pend_q(pend),
    .pen_q(pen), .wd_q(wd), .bp_q(bp), .grant_q(sts_grant),
    .deny_q(sts_deny), .done_o(sts_done)
  );

  always_comb begin
    arr_grant_d = arr_req && arr_ok;
    arr_deny_d  = arr_req && !arr_ok;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      arr_grant_q <= 1'b0;
      arr_deny_q  <= 1'b0;
    end else begin
      arr_grant_q <= arr_grant_d;
      arr_deny_q  <= arr_deny_d;
    end
  end

  assign arr_grant = arr_grant_q;
  assign arr_deny  = arr_deny_q;

  always_comb begin
    status_rd         = 8'h00;
    status_rd[SB_PEN] = pen;
    status_rd[SB_WDH] = wd[1];
    status_rd[SB_WDL] = wd[0];
    status_rd[SB_BPH] = bp[1];
    status_rd[SB_BPL] = bp[0];
    status_rd[SB_WEL] = wel;
    status_rd[SB_RDY] = busy;
  end

  a_r5_one_verdict: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0({arr_grant, arr_deny, sts_grant, sts_deny}));

  a_r7_latch_low_after_write: assert property (@(posedge clk) disable iff (!rst_i)
    (arr_grant || arr_deny || sts_grant || sts_deny) |-> !wel);

  a_r4_busy_freezes: assert property (@(posedge clk) disable iff (!rst_i)
    (busy && !pend) |=> ($stable(wel) && $stable(status_rd[7:2]) && !arr_grant && !arr_deny));

  a_r6_no_grant_in_region: assert property (@(posedge clk) disable iff (!rst_i)
    arr_grant |-> !$past(prot));

  a_r6_all_blocked: assert property (@(posedge clk) disable iff (!rst_i)
    (bp == 2'b11) |=> !arr_grant);
endmodule

// File: tb/sim_status_guard.sv
module sim_status_guard;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = 3'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_data = 8'h00;
  logic          cs_n = 1'b1;
  logic          wp_n = 1'b1;
  logic          busy = 1'b0;
  logic [7:0]    status_rd;
  logic          arr_grant, arr_deny, sts_grant, sts_deny;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  status_guard #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cs_n(cs_n), .wp_n(wp_n),
    .busy(busy), .status_rd(status_rd), .arr_grant(arr_grant),
    .arr_deny(arr_deny), .sts_grant(sts_grant), .sts_deny(sts_deny)
  );

  // behavioural reference
  int m_pen, m_wd, m_bp, m_wel, m_pend, m_buf;
  int m_ag, m_ad, m_sg, m_sd;

  function automatic int protected_at(int bpv, int a);
    if (bpv == 0) return 0;
    if (bpv == 1) return (a >= (3 << (AW - 2))) ? 1 : 0;
    if (bpv == 2) return (a >= (1 << (AW - 1))) ? 1 : 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    m_ag = 0; m_ad = 0; m_sg = 0; m_sd = 0;
    if (!rst_n) begin
      m_pen = 0; m_wd = 0; m_bp = 0; m_wel = 0; m_pend = 0; m_buf = 0;
    end else if (m_pend != 0) begin
      if (cs_n) begin
        m_pen = (m_buf >> 7) & 1; m_wd = (m_buf >> 4) & 3; m_bp = (m_buf >> 2) & 3;
        m_wel = 0; m_pend = 0; m_sg = 1;
      end else if (m_pen != 0 && !wp_n) begin
        m_wel = 0; m_pend = 0; m_sd = 1;
      end
    end else if (cmd_valid && !busy) begin
      if (cmd_op == 3'd1) m_wel = 1;
      else if (cmd_op == 3'd2) m_wel = 0;
      else if (cmd_op == 3'd3) begin
        if (m_wel != 0 && !(m_pen != 0 && !wp_n)) begin m_pend = 1; m_buf = cmd_data; end
        else begin m_wel = 0; m_sd = 1; end
      end else if (cmd_op == 3'd4) begin
        if (m_wel != 0 && protected_at(m_bp, int'(cmd_addr)) == 0) m_ag = 1;
        else m_ad = 1;
        m_wel = 0;
      end
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      int exp_s;
      exp_s = (m_pen << 7) | (m_wd << 4) | (m_bp << 2) | (m_wel << 1) | (busy ? 1 : 0);
      checks++;
      if (int'(status_rd) != exp_s) begin
        failures++;
        $display("FAIL R8 model status act=%02h exp=%02h t=%0t", status_rd, exp_s, $time);
      end
      checks++;
      if ({arr_grant, arr_deny} != {m_ag[0], m_ad[0]}) begin
        failures++;
        $display("FAIL R5 model array verdict act=%b%b exp=%0d%0d t=%0t",
                 arr_grant, arr_deny, m_ag, m_ad, $time);
      end
      checks++;
      if ({sts_grant, sts_deny} != {m_sg[0], m_sd[0]}) begin
        failures++;
        $display("FAIL R9 model status verdict act=%b%b exp=%0d%0d t=%0t",
                 sts_grant, sts_deny, m_sg, m_sd, $time);
      end
    end
  end

  task automatic step(input logic v, input logic [2:0] op, input int addr,
                      input logic [7:0] data, input logic cs, input logic wp,
                      input logic bz);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_addr = AW'(addr); cmd_data = data;
    cs_n = cs; wp_n = wp; busy = bz;
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int verdicts();
    return {arr_grant, arr_deny, sts_grant, sts_deny};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(0, 0, 0, 0, 1, 1, 0);
    chk("R1 reset status", status_rd, 8'h00);

    step(0, 0, 0, 0, 1, 1, 1);
    chk("R2 ready bit while busy", status_rd, 8'h01);
    step(0, 0, 0, 0, 1, 1, 0);

    step(1, 3'd1, 0, 0, 1, 1, 0);
    chk("R3 latch set", status_rd, 8'h02);
    step(1, 3'd6, 0, 0, 1, 1, 0);
    chk("R3 unused code ignored", status_rd, 8'h02);
    step(1, 3'd2, 0, 0, 1, 1, 0);
    chk("R3 latch clear", status_rd, 8'h00);

    step(1, 3'd1, 0, 0, 1, 1, 0);
    step(1, 3'd4, 6'h3F, 0, 1, 1, 0);
    chk("R5 array grant unprotected", verdicts(), 4'b1000);
    chk("R7 latch low after grant", status_rd, 8'h00);
    step(1, 3'd4, 6'h00, 0, 1, 1, 0);
    chk("R5 array deny without latch", verdicts(), 4'b0100);

    step(1, 3'd1, 0, 0, 1, 1, 0);
    step(1, 3'd3, 0, 8'hFF, 0, 1, 0);
    chk("R8 no store while cs low", verdicts() * 256 + status_rd, 8'h02);
    step(0, 0, 0, 0, 1, 1, 0);
    chk("R8 store on cs high", verdicts(), 4'b0010);
    chk("R8 writable bits only", status_rd, 8'hBC);

    step(1, 3'd1, 0, 0, 1, 1, 0);
    step(1, 3'd4, 6'h00, 0, 1, 1, 0);
    chk("R6 all protected", verdicts(), 4'b0100);

    step(1, 3'd1, 0, 0, 1, 0, 0);
    step(1, 3'd3, 0, 8'h00, 0, 0, 0);
    chk("R9 hardware lock deny", verdicts(), 4'b0001);
    chk("R9 fields kept", status_rd, 8'hBC);

    step(1, 3'd1, 0, 0, 1, 1, 0);
    step(1, 3'd3, 0, 8'h84, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R11 abort before start", verdicts(), 4'b0001);
    chk("R11 abort keeps fields", status_rd, 8'hBC);

    step(1, 3'd1, 0, 0, 1, 1, 0);
    step(1, 3'd3, 0, 8'h84, 0, 1, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    chk("R11 started write stored", verdicts(), 4'b0010);
    chk("R11 stored value", status_rd, 8'h84);

    step(1, 3'd1, 0, 0, 1, 1, 0);
    step(1, 3'd4, 6'h30, 0, 1, 1, 0);
    chk("R6 quarter edge protected", verdicts(), 4'b0100);
    step(1, 3'd1, 0, 0, 1, 1, 0);
    step(1, 3'd4, 6'h2F, 0, 1, 1, 0);
    chk("R6 below quarter granted", verdicts(), 4'b1000);

    step(1, 3'd1, 0, 0, 1, 1, 0);
    step(1, 3'd3, 0, 8'h08, 0, 1, 0);
    step(0, 0, 0, 0, 1, 1, 0);
    chk("R8 half mode stored", status_rd, 8'h08);
    step(1, 3'd1, 0, 0, 1, 1, 0);
    step(1, 3'd4, 6'h20, 0, 1, 1, 0);
    chk("R6 half edge protected", verdicts(), 4'b0100);
    step(1, 3'd1, 0, 0, 1, 1, 0);
    step(1, 3'd4, 6'h1F, 0, 1, 1, 0);
    chk("R6 below half granted", verdicts(), 4'b1000);

    step(1, 3'd1, 0, 0, 1, 0, 0);
    step(1, 3'd3, 0, 8'h0C, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R10 pin inert while pending", verdicts(), 4'b0000);
    step(0, 0, 0, 0, 1, 0, 0);
    chk("R10 pin inert when bit7 clear", verdicts(), 4'b0010);
    chk("R10 stored", status_rd, 8'h0C);

    step(1, 3'd1, 0, 0, 1, 1, 0);
    step(1, 3'd2, 0, 0, 1, 1, 1);
    chk("R4 clear ignored while busy", status_rd, 8'h0F);
    step(1, 3'd4, 6'h00, 0, 1, 1, 1);
    chk("R4 array write ignored while busy", verdicts(), 4'b0000);
    step(1, 3'd3, 0, 8'h00, 1, 1, 1);
    step(0, 0, 0, 0, 1, 1, 1);
    chk("R4 status write ignored while busy", verdicts() * 256 + status_rd, 8'h0F);
    step(0, 0, 0, 0, 1, 1, 0);
    chk("R2 ready bit drops", status_rd, 8'h0E);

    for (int i = 0; i < 600; i++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 5));
      step($urandom_range(0, 2) != 0, o, $urandom_range(0, 63), 8'($urandom),
           $urandom_range(0, 2) == 0, $urandom_range(0, 2) != 0,
           $urandom_range(0, 7) == 0);
    end

    step(0, 0, 0, 0, 1, 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule